// File: doc/BRIEF.md
# Priority Iterative Crossbar Scheduler

This block decides, once per scheduling epoch, which input port of an N-port switch may send to which output port. Each input port reports a demand by naming a target output and a priority level. The scheduler keeps every reported demand in a per-output pending store. It then runs a fixed number of request, grant and accept rounds, in which higher-priority demands always win. Ports that pair up in one round are left out of the later rounds. The resulting one-to-one pairing sets up short-lived dedicated circuits through the crossbar, so the data path needs no queue.

A demand is the only way to obtain a grant. A write transfer therefore announces itself as a demand and waits for its grant before it sends any data. A demand leaves the store only when its pairing is accepted at the end of an epoch. A demand that loses stays pending and competes again in the next epoch. When two demands have equal priority, a rotating pointer kept per output (for grants) and per input (for accepts) decides between them, so no port is locked out.

Top module: `pim_sched`

## Requirements
- R1: An output that receives several requests grants the one with the numerically highest priority (priority 3 beats priority 0).
- R2: An input that receives several grants accepts the one carrying the numerically highest priority.
- R3: Each round takes exactly 3 cycles and an epoch has ITER rounds. `epoch_tick` pulses once every 3*ITER cycles, and the first pulse comes 3*ITER cycles after reset is released.
- R4: Ports paired in an earlier round of an epoch are excluded from later rounds. A port left unpaired in round 0 can still be paired in a later round of the same epoch.
- R5: The published pairing is one-to-one: no output appears against two valid inputs.
- R6: Ties of equal priority are broken by a rotating pointer. The pointer starts at port 0 after reset. After a pairing in→out is accepted, the output's grant pointer becomes in+1 and the input's accept pointer becomes out+1, both modulo N. The winner is the first tied candidate at or after the pointer.
- R7: A demand is removed only when its pairing is accepted. Demands that lose remain pending for the following epochs.
- R8: When a new demand for the same input, output and priority arrives in the same cycle in which that slot is removed, the new demand is kept.
- R9: Reset clears all pending demands and pointers. Demands presented during reset are dropped, and no grant is issued before the first full epoch has completed.
- R10: A port with no pending demand gets no grant and shows `match_valid` low in the published pairing.
- R11: `grant` pulses only in the cycle of `epoch_tick` and equals that epoch's `match_valid`. `match_valid` and `match_port` are held until the next `epoch_tick`. Port i's target is in `match_port[i*IW +: IW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | N | Per-input demand strobe, one cycle per demand |
| dmd_dest | input | N*IW | Target output of each input's demand, field i at [i*IW +: IW] |
| dmd_prio | input | N*PW | Priority of each input's demand, field i at [i*PW +: PW]; larger is more urgent |
| match_valid | output | N | Input i holds a circuit in the current pairing |
| match_port | output | N*IW | Output paired with input i, field i at [i*IW +: IW] |
| grant | output | N | One-cycle grant notification to each paired input |
| epoch_tick | output | 1 | One-cycle pulse when a new pairing is published |

## Verification
At the end of an epoch, two things can hit the same pending slot in one cycle: the removal of an accepted demand, and a fresh demand from the same input to the same output at the same priority. The bench provokes this by sending the winning input's demand again in the exact cycle its first pairing is published. It then watches two following epochs. The rival input must win the next epoch through the rotated grant pointer, and the re-sent demand must still be pending and win the epoch after that. Both results are judged purely at `match_valid` and `match_port`.

// File: rtl/pim_pkg.sv
// Package: shared types for the crossbar scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package pim_pkg;

    // Step of one matching round.
    typedef enum logic [1:0] {
        PH_REQ = 2'd0,
        PH_GNT = 2'd1,
        PH_ACC = 2'd2
    } phase_e;

endpackage

// File: rtl/pim_arbiter.sv
// Module: priority-first, rotating-tiebreak picker.
// Picks one of W requesters: highest priority first, then the first tied
// requester at or after ptr. Purely combinational.
// Assumes: ptr < W, priorities are unsigned.
module pim_arbiter #(
    parameter int W  = 4,
    parameter int PW = 2,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]    req,
    input  logic [W*PW-1:0] prio,
    input  logic [IW-1:0]   ptr,
    output logic            pick_v,
    output logic [IW-1:0]   pick_idx,
    output logic [PW-1:0]   pick_prio
);

    logic [PW-1:0] top_p;

    // Find the highest priority among active requesters.
    always_comb begin
        top_p  = '0;
        pick_v = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (req[k] && (!pick_v || prio[k*PW +: PW] > top_p)) begin
                top_p  = prio[k*PW +: PW];
                pick_v = 1'b1;
            end
        end
    end

    // Walk from the pointer and take the first requester at that priority.
    always_comb begin
        logic found;
        int   idx;
        found     = 1'b0;
        pick_idx  = '0;
        pick_prio = top_p;
        for (int k = 0; k < W; k++) begin
            idx = int'(ptr) + k;
            if (idx >= W) idx = idx - W;
            if (!found && req[idx] && prio[idx*PW +: PW] == top_p) begin
                found    = 1'b1;
                pick_idx = IW'(idx);
            end
        end
    end

    // The pick is an active requester and nobody outranks it.
    always_comb begin
        if (pick_v) begin
            assert_pick_requested_R1: assert (req[pick_idx]);
            for (int k = 0; k < W; k++) begin
                if (req[k]) begin
                    assert_pick_highest_R1: assert (prio[k*PW +: PW] <= pick_prio);
                end
            end
        end
    end

endmodule

// File: rtl/pim_demand_store.sv
// Module: pending-demand store.
// One bit per (output, input, priority) slot. Insert sets a bit; remove clears
// one. Each (output, input) pair reports its best pending priority through a
// parallel encoder, so insert and extract take constant time.
// Assumes: a repeated demand for an already pending slot merges with it;
// a destination >= N is dropped.
module pim_demand_store #(
    parameter int N = 4,
    parameter int P = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int PW = (P > 1) ? $clog2(P) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    ins_v,
    input  logic [N*IW-1:0] ins_dest,
    input  logic [N*PW-1:0] ins_prio,
    input  logic [N-1:0]    rem_v,
    input  logic [N*IW-1:0] rem_out,
    input  logic [N*PW-1:0] rem_prio,
    output logic [N*N-1:0]    pair_v,
    output logic [N*N*PW-1:0] pair_prio
);

    logic [P-1:0] slots   [N][N];
    logic [P-1:0] set_m   [N][N];
    logic [P-1:0] clr_m   [N][N];

    // Decode this cycle's insert and remove requests into slot masks.
    always_comb begin
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                set_m[o][i] = '0;
                clr_m[o][i] = '0;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (ins_v[i] && int'(ins_dest[i*IW +: IW]) < N && int'(ins_prio[i*PW +: PW]) < P)
                set_m[ins_dest[i*IW +: IW]][i][ins_prio[i*PW +: PW]] = 1'b1;
            if (rem_v[i] && int'(rem_out[i*IW +: IW]) < N && int'(rem_prio[i*PW +: PW]) < P)
                clr_m[rem_out[i*IW +: IW]][i][rem_prio[i*PW +: PW]] = 1'b1;
        end
    end

    // Update the slots; an insert wins over a removal of the same slot.
    always_ff @(posedge clk) begin
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                if (!rst_n) slots[o][i] <= '0;
                else        slots[o][i] <= (slots[o][i] & ~clr_m[o][i]) | set_m[o][i];
            end
        end
    end

    // Report the best pending priority of every (output, input) pair.
    generate
        for (genvar o = 0; o < N; o++) begin : g_out
            for (genvar i = 0; i < N; i++) begin : g_in
                always_comb begin
                    pair_v[o*N+i] = |slots[o][i];
                    pair_prio[(o*N+i)*PW +: PW] = '0;
                    for (int p = 0; p < P; p++) begin
                        if (slots[o][i][p]) pair_prio[(o*N+i)*PW +: PW] = PW'(p);
                    end
                end
            end
        end
        for (genvar i = 0; i < N; i++) begin : g_chk
            // Only a pending demand can be removed.
            assert_remove_queued_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rem_v[i] |-> slots[rem_out[i*IW +: IW]][i][rem_prio[i*PW +: PW]]);
        end
    endgenerate

endmodule

// File: rtl/pim_sched.sv
// Module: top of the priority iterative crossbar scheduler.
// Runs ITER rounds per epoch; each round is request, grant and accept, one
// cycle apiece. At the end of the epoch it publishes the pairing, pulses the
// grants and removes the accepted demands from the store.
// Assumes: demands arriving during an epoch join in the next request step.
module pim_sched #(
    parameter int N    = 4,
    parameter int P    = 4,
    parameter int ITER = 3,
    localparam int IW    = (N > 1) ? $clog2(N) : 1,
    localparam int PW    = (P > 1) ? $clog2(P) : 1,
    localparam int ITW   = (ITER > 1) ? $clog2(ITER) : 1,
    localparam int EPOCH = 3 * ITER,
    localparam int CW    = $clog2(EPOCH + 1) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    dmd_valid,
    input  logic [N*IW-1:0] dmd_dest,
    input  logic [N*PW-1:0] dmd_prio,
    output logic [N-1:0]    match_valid,
    output logic [N*IW-1:0] match_port,
    output logic [N-1:0]    grant,
    output logic            epoch_tick
);
    import pim_pkg::*;

    phase_e          ph;
    logic [ITW-1:0]  it;
    logic            last_acc;

    logic [N*N-1:0]    pair_v;
    logic [N*N*PW-1:0] pair_prio;
    logic [N*N-1:0]    req_n, req_r;
    logic [N*N*PW-1:0] reqp_r;

    logic [N-1:0]    in_m, out_m;
    logic [N-1:0]    cur_v;
    logic [N*IW-1:0] cur_port;
    logic [N*PW-1:0] cur_prio;

    logic [N*IW-1:0] gptr, aptr;
    logic [N-1:0]    g_v, gv_r;
    logic [N*IW-1:0] g_i, gi_r;
    logic [N*PW-1:0] g_p, gp_r;

    logic [N*N-1:0]    acc_req;
    logic [N*N*PW-1:0] acc_prio;
    logic [N-1:0]      a_v;
    logic [N*IW-1:0]   a_o;
    logic [N*PW-1:0]   a_p;
    logic [N-1:0]      acc_out_mask;

    logic [N-1:0]    nxt_v;
    logic [N*IW-1:0] nxt_port;
    logic [N*PW-1:0] nxt_prio;
    logic [N-1:0]    rem_v;

    assign last_acc = (ph == PH_ACC) && (it == ITW'(ITER - 1));
    assign rem_v    = last_acc ? nxt_v : '0;

    // Pending demands: insert from the ports, remove accepted pairings.
    pim_demand_store #(.N(N), .P(P)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_v    (dmd_valid),
        .ins_dest (dmd_dest),
        .ins_prio (dmd_prio),
        .rem_v    (rem_v),
        .rem_out  (nxt_port),
        .rem_prio (nxt_prio),
        .pair_v   (pair_v),
        .pair_prio(pair_prio)
    );

    // Request step: pending pairs whose two ports are both still free.
    always_comb begin
        for (int o = 0; o < N; o++)
            for (int i = 0; i < N; i++)
                req_n[o*N+i] = pair_v[o*N+i] & ~in_m[i] & ~out_m[o];
    end

    // Grant step: one arbiter per output over its requesting inputs.
    generate
        for (genvar o = 0; o < N; o++) begin : g_garb
            pim_arbiter #(.W(N), .PW(PW)) u_garb (
                .req      (req_r[o*N +: N]),
                .prio     (reqp_r[o*N*PW +: N*PW]),
                .ptr      (gptr[o*IW +: IW]),
                .pick_v   (g_v[o]),
                .pick_idx (g_i[o*IW +: IW]),
                .pick_prio(g_p[o*PW +: PW])
            );
        end
    endgenerate

    // Accept step inputs: regroup the registered grants by input.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) begin
                acc_req[i*N+o] = gv_r[o] && (gi_r[o*IW +: IW] == IW'(i));
                acc_prio[(i*N+o)*PW +: PW] = gp_r[o*PW +: PW];
            end
        end
    end

    // Accept step: one arbiter per input over the outputs granting it.
    generate
        for (genvar i = 0; i < N; i++) begin : g_aarb
            pim_arbiter #(.W(N), .PW(PW)) u_aarb (
                .req      (acc_req[i*N +: N]),
                .prio     (acc_prio[i*N*PW +: N*PW]),
                .ptr      (aptr[i*IW +: IW]),
                .pick_v   (a_v[i]),
                .pick_idx (a_o[i*IW +: IW]),
                .pick_prio(a_p[i*PW +: PW])
            );
        end
    endgenerate

    // Pairing after this accept step: earlier rounds plus new acceptances.
    always_comb begin
        acc_out_mask = '0;
        nxt_v        = cur_v | a_v;
        nxt_port     = '0;
        nxt_prio     = '0;
        for (int i = 0; i < N; i++) begin
            if (a_v[i]) begin
                acc_out_mask[a_o[i*IW +: IW]] = 1'b1;
                nxt_port[i*IW +: IW] = a_o[i*IW +: IW];
                nxt_prio[i*PW +: PW] = a_p[i*PW +: PW];
            end else if (cur_v[i]) begin
                nxt_port[i*IW +: IW] = cur_port[i*IW +: IW];
                nxt_prio[i*PW +: PW] = cur_prio[i*PW +: PW];
            end
        end
    end

    // Round sequencer, pointer updates and end-of-epoch publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_REQ;  it <= '0;
            req_r <= '0;   reqp_r <= '0;
            gv_r <= '0;    gi_r <= '0;   gp_r <= '0;
            in_m <= '0;    out_m <= '0;
            cur_v <= '0;   cur_port <= '0; cur_prio <= '0;
            gptr <= '0;    aptr <= '0;
            match_valid <= '0; match_port <= '0;
            grant <= '0;   epoch_tick <= 1'b0;
        end else begin
            grant      <= '0;
            epoch_tick <= 1'b0;
            case (ph)
                PH_REQ: begin
                    req_r  <= req_n;
                    reqp_r <= pair_prio;
                    ph     <= PH_GNT;
                end
                PH_GNT: begin
                    gv_r <= g_v;
                    gi_r <= g_i;
                    gp_r <= g_p;
                    ph   <= PH_ACC;
                end
                default: begin
                    ph <= PH_REQ;
                    for (int i = 0; i < N; i++) begin
                        if (a_v[i]) begin
                            gptr[int'(a_o[i*IW +: IW])*IW +: IW] <= IW'((i + 1) % N);
                            aptr[i*IW +: IW] <= IW'((int'(a_o[i*IW +: IW]) + 1) % N);
                        end
                    end
                    if (last_acc) begin
                        match_valid <= nxt_v;
                        match_port  <= nxt_port;
                        grant       <= nxt_v;
                        epoch_tick  <= 1'b1;
                        in_m  <= '0;
                        out_m <= '0;
                        cur_v <= '0;
                        it    <= '0;
                    end else begin
                        in_m     <= in_m | a_v;
                        out_m    <= out_m | acc_out_mask;
                        cur_v    <= nxt_v;
                        cur_port <= nxt_port;
                        cur_prio <= nxt_prio;
                        it       <= it + 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- checks ----------------
    logic [CW-1:0] chk_cnt;
    logic          dup_out;

    // Cycles since reset or since the previous publication.
    always_ff @(posedge clk) begin
        if (!rst_n)          chk_cnt <= '0;
        else if (epoch_tick) chk_cnt <= CW'(1);
        else                 chk_cnt <= chk_cnt + 1'b1;
    end

    // Look for an output that appears twice in the published pairing.
    always_comb begin
        dup_out = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (match_valid[a] && match_valid[b] &&
                    match_port[a*IW +: IW] == match_port[b*IW +: IW])
                    dup_out = 1'b1;
    end

    assert_one_to_one_R5: assert property (@(posedge clk) disable iff (!rst_n) !dup_out);
    assert_balanced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_m) == $countones(out_m));
    assert_epoch_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_tick |-> (chk_cnt == CW'(EPOCH)));
    assert_grant_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> epoch_tick);
    assert_hold_pairing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_tick |=> $stable(match_valid) || epoch_tick);

endmodule

// File: tb/pim_sched_test.sv
// Bench: table-driven pairing checks, then directed reset and corner tests.
module pim_sched_test;
    localparam int N = 4, P = 4, ITER = 3;
    localparam int EPOCH = 3 * ITER;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dmd_valid = '0;
    logic [7:0] dmd_dest = '0;
    logic [7:0] dmd_prio = '0;
    logic [3:0] match_valid;
    logic [7:0] match_port;
    logic [3:0] grant;
    logic       epoch_tick;

    int errors = 0;
    int checks = 0;

    pim_sched #(.N(N), .P(P), .ITER(ITER)) uut (
        .clk(clk), .rst_n(rst_n),
        .dmd_valid(dmd_valid), .dmd_dest(dmd_dest), .dmd_prio(dmd_prio),
        .match_valid(match_valid), .match_port(match_port),
        .grant(grant), .epoch_tick(epoch_tick)
    );

    always #10 clk = ~clk;

    // Fields: vA dA pA | vB dB pB | expected valid, expected ports.
    localparam logic [51:0] VEC [6] = '{
        {4'b1111, 8'b00111001, 8'h00, 4'b0000, 8'h00, 8'h00, 4'b1111, 8'b00111001}, // R5 full permutation
        {4'b0111, 8'b00101010, 8'b00101101, 4'b0000, 8'h00, 8'h00, 4'b0010, 8'b00001000}, // R1
        {4'b0001, 8'b00000001, 8'b00000001, 4'b0001, 8'b00000011, 8'b00000010, 4'b0001, 8'b00000011}, // R2
        {4'b1010, 8'h00, 8'b10001000, 4'b0000, 8'h00, 8'h00, 4'b0010, 8'h00}, // R6 grant tie
        {4'b0011, 8'h00, 8'b00001011, 4'b0011, 8'b00000101, 8'b00000001, 4'b0011, 8'b00000100}, // R4
        {4'b0100, 8'b00010000, 8'b00010000, 4'b0100, 8'b00110000, 8'b00010000, 4'b0100, 8'b00010000} // R6 accept tie
    };
    localparam string VNAME [6] = '{"R5", "R1", "R2", "R6", "R4", "R6"};

    task automatic check(input logic ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        dmd_valid = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Advance to the negedge just after the next publication.
    task automatic sync();
        do @(negedge clk); while (!epoch_tick);
    endtask

    // From a publication negedge, insert two demand cycles late in the epoch.
    task automatic inject(input logic [3:0] va, input logic [7:0] da, input logic [7:0] pa,
                          input logic [3:0] vb, input logic [7:0] db, input logic [7:0] pb);
        repeat (7) @(negedge clk);
        dmd_valid = va; dmd_dest = da; dmd_prio = pa;
        @(negedge clk);
        dmd_valid = vb; dmd_dest = db; dmd_prio = pb;
        @(negedge clk);
        dmd_valid = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int n;
        // R9: demands presented during reset are dropped; nothing before the first epoch.
        dmd_valid = 4'b1111; dmd_dest = 8'b00111001; dmd_prio = 8'hFF;
        repeat (3) @(negedge clk);
        dmd_valid = '0;
        rst_n = 1'b1;
        check(match_valid == 4'b0 && grant == 4'b0, "R9 reset state", match_valid, 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!epoch_tick) check(grant == 4'b0, "R9 early grant", grant, 0);
        end while (!epoch_tick);
        check(n == EPOCH, "R3 first epoch length", n, EPOCH);
        check(match_valid == 4'b0, "R9 reset-time demands dropped", match_valid, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!epoch_tick);
        check(n == EPOCH, "R3 epoch period", n, EPOCH);

        // Table walk: each entry starts from reset.
        for (int v = 0; v < 6; v++) begin
            logic [51:0] e;
            e = VEC[v];
            do_reset();
            sync();
            inject(e[51:48], e[47:40], e[39:32], e[31:28], e[27:20], e[19:12]);
            sync();
            check(match_valid == e[11:8], {VNAME[v], " valid"}, match_valid, e[11:8]);
            check(match_port == e[7:0], {VNAME[v], " port"}, match_port, e[7:0]);
            check(grant == e[11:8], "R11 grant at tick", grant, e[11:8]);
            @(negedge clk);
            check(grant == 4'b0 && match_valid == e[11:8], "R11 pulse and hold",
                  {grant, match_valid}, {4'b0, e[11:8]});
        end

        // R7 / R10: losers persist, winners leave, then nothing remains.
        do_reset();
        sync();
        inject(4'b0111, 8'b00101010, 8'b00101101, 4'b0000, 8'h00, 8'h00);
        sync();
        check(match_valid == 4'b0010, "R1 first winner", match_valid, 4'b0010);
        sync();
        check(match_valid == 4'b0100 && match_port == 8'b00100000, "R7 loser kept",
              {match_valid, match_port}, {4'b0100, 8'b00100000});
        sync();
        check(match_valid == 4'b0001 && match_port == 8'b00000010, "R7 last loser",
              {match_valid, match_port}, {4'b0001, 8'b00000010});
        sync();
        check(match_valid == 4'b0000 && grant == 4'b0000, "R10 no demand no grant",
              {match_valid, grant}, 0);

        // R6 / R8: rotation after a win, and a re-sent demand at removal time.
        do_reset();
        sync();
        inject(4'b1010, 8'h00, 8'b10001000, 4'b0000, 8'h00, 8'h00);
        repeat (8) @(negedge clk);
        dmd_valid = 4'b0010; dmd_dest = 8'h00; dmd_prio = 8'b00001000;
        @(negedge clk);
        dmd_valid = '0;
        check(epoch_tick && match_valid == 4'b0010, "R6 pointer start",
              {epoch_tick, match_valid}, {1'b1, 4'b0010});
        sync();
        check(match_valid == 4'b1000 && match_port == 8'h00, "R6 rotated winner",
              {match_valid, match_port}, {4'b1000, 8'h00});
        sync();
        check(match_valid == 4'b0010 && match_port == 8'h00, "R8 insert beats removal",
              {match_valid, match_port}, {4'b0010, 8'h00});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule